// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block sequences a battery-backed memory through loss and return of its main supply. Three external comparators report whether the rail sits above the full-operation level, above the protect level, and above the roughly 3 V switchover level. The block passes each flag through a two-flop synchroniser and runs a four-state machine: sealed, normal, protected and backup. Its outputs gate the memory interface: they block writes, mark the inputs as ignored and force the outputs to high impedance. They also close the switch that feeds the array from the backup cell.

The protect and resume levels differ, so the supply has to climb past the higher full-operation level before access is restored. Dropping below the lower protect level is what removes access. A part leaves the factory in the sealed state with the backup source disconnected. The first time the rail rises past the protect level, the seal is released and backup is armed for every later outage. The variant-dependent trip voltages are set in the comparators. The sequencing here is the same for every variant.

Top module: `pfail_seq`

## Requirements
- R1: While `rst_n` is low and after its release with all flags low, `state_o` is 0 (sealed), the three gate outputs are 1, `backup_on_o` is 0 and `seal_released_o` is 0. State codes are: 0 sealed, 1 normal, 2 protected, 3 backup.
- R2: In the sealed state, a synchronised protect flag releases the seal. The machine moves to normal if the full flag is also high and to protected otherwise. `seal_released_o` then stays 1 until reset, and the sealed state is never re-entered.
- R3: In the sealed state, a low switchover flag leaves `backup_on_o` at 0 and the state at sealed.
- R4: Normal is entered only from sealed or protected, and only when the synchronised full flag is high. The three gate outputs are 0 only in normal while the synchronised protect flag is high.
- R5: In normal, a fall of the full flag alone (protect still high) keeps the state at normal with the gates open.
- R6: When the protect flag falls in normal, all three gates assert in the same cycle that the synchronised flag falls. This is two clock edges after the input changes, with no further register.
- R7: After the seal is released, a low synchronised switchover flag moves the machine to backup, and `backup_on_o` is 1 exactly in backup.
- R8: In backup, a returning switchover flag moves to protected and disconnects the backup source. Normal follows only once the full flag is high.
- R9: Each flag reaches the state machine through two flops, so a state change appears three edges after the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, returns to sealed |
| above_full_i | input | 1 | Asynchronous flag: rail above full-operation level |
| above_prot_i | input | 1 | Asynchronous flag: rail above protect level |
| above_swo_i | input | 1 | Asynchronous flag: rail above switchover level |
| write_protect_o | output | 1 | 1 blocks writes to the array |
| inputs_ignored_o | output | 1 | 1 makes memory inputs don't-care |
| outputs_hiz_o | output | 1 | 1 forces memory data outputs to high impedance |
| backup_on_o | output | 1 | 1 feeds the array from the backup source |
| seal_released_o | output | 1 | Sticky: backup has been armed since reset |
| state_o | output | 2 | Sequencer state code |

## Verification
The assertions take the comparator flags to be nested, as any falling or rising rail makes them: full high implies protect high, and protect high implies switchover high. Under that assumption, leaving backup always lands in protected, and open gates always mean normal. The stimulus drives a single supply level from 0 to 3 that sets all three flags together, so no inconsistent combination ever arises. It holds each level for more cycles than the synchroniser and two state steps need. Every sequence of four levels after reset is applied.

// File: rtl/pfs_pkg.sv
// Shared types for the power-fail sequencer.
// Assumes: state codes are visible at the top port and must stay fixed.
package pfs_pkg;
    localparam int NUM_FLAGS = 3;
    localparam int FLAG_SWO  = 0;
    localparam int FLAG_PROT = 1;
    localparam int FLAG_FULL = 2;

    typedef enum logic [1:0] {
        ST_SEALED    = 2'd0,
        ST_NORMAL    = 2'd1,
        ST_PROTECTED = 2'd2,
        ST_BACKUP    = 2'd3
    } pfs_state_e;
endpackage

// File: rtl/pfs_sync.sv
// Multi-stage synchroniser bank for asynchronous comparator flags.
// Assumes: each bit is independent; reset value is 0 (rail absent).
module pfs_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the raw flags.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= '0;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_next
                // Later stages shift the previous stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= '0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pfs_fsm.sv
// Sequencer state machine with the one-time seal latch.
// Assumes: flags are synchronised and nested (full -> prot -> swo).
module pfs_fsm
    import pfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       full_s,
    input  logic       prot_s,
    input  logic       swo_s,
    output pfs_state_e state_o,
    output logic       seal_o
);
    pfs_state_e state_q, state_d;
    logic       seal_q;

    // Next-state selection from the current state and synchronised flags.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEALED: begin
                if (prot_s) state_d = full_s ? ST_NORMAL : ST_PROTECTED;
            end
            ST_NORMAL: begin
                if (!prot_s) state_d = swo_s ? ST_PROTECTED : ST_BACKUP;
            end
            ST_PROTECTED: begin
                if (full_s && prot_s) state_d = ST_NORMAL;
                else if (!swo_s)      state_d = ST_BACKUP;
            end
            ST_BACKUP: begin
                if (swo_s) state_d = ST_PROTECTED;
            end
            default: state_d = ST_SEALED;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SEALED;
        else        state_q <= state_d;
    end

    // Seal latch: set on first valid power application, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                              seal_q <= 1'b0;
        else if (state_q == ST_SEALED && prot_s) seal_q <= 1'b1;
    end

    assign state_o = state_q;
    assign seal_o  = seal_q;
endmodule

// File: rtl/pfs_gate.sv
// Output gating for the memory interface and the backup switch.
// Assumes: protect flag is the synchronised one; gating reacts to it
// combinationally so protection needs no extra register.
module pfs_gate
    import pfs_pkg::*;
(
    input  pfs_state_e state_i,
    input  logic       prot_s,
    output logic       write_protect_o,
    output logic       inputs_ignored_o,
    output logic       outputs_hiz_o,
    output logic       backup_on_o
);
    logic access_ok;

    // Access is open only in normal with the rail above the protect level.
    always_comb begin
        access_ok        = (state_i == ST_NORMAL) && prot_s;
        write_protect_o  = !access_ok;
        inputs_ignored_o = !access_ok;
        outputs_hiz_o    = !access_ok;
        backup_on_o      = (state_i == ST_BACKUP);
    end
endmodule

// File: rtl/pfail_seq.sv
// Top of the power-fail write-protect sequencer.
// Assumes: comparator flags are asynchronous and nested; reset is
// synchronous active-low and returns the block to the sealed state.
module pfail_seq
    import pfs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       above_full_i,
    input  logic       above_prot_i,
    input  logic       above_swo_i,
    output logic       write_protect_o,
    output logic       inputs_ignored_o,
    output logic       outputs_hiz_o,
    output logic       backup_on_o,
    output logic       seal_released_o,
    output logic [1:0] state_o
);
    logic [NUM_FLAGS-1:0] flags_raw, flags_s;
    pfs_state_e           state;

    assign flags_raw[FLAG_SWO]  = above_swo_i;
    assign flags_raw[FLAG_PROT] = above_prot_i;
    assign flags_raw[FLAG_FULL] = above_full_i;

    pfs_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(flags_raw),
        .sync_o (flags_s)
    );

    pfs_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .full_s (flags_s[FLAG_FULL]),
        .prot_s (flags_s[FLAG_PROT]),
        .swo_s  (flags_s[FLAG_SWO]),
        .state_o(state),
        .seal_o (seal_released_o)
    );

    pfs_gate u_gate (
        .state_i         (state),
        .prot_s          (flags_s[FLAG_PROT]),
        .write_protect_o (write_protect_o),
        .inputs_ignored_o(inputs_ignored_o),
        .outputs_hiz_o   (outputs_hiz_o),
        .backup_on_o     (backup_on_o)
    );

    assign state_o = state;
endmodule

// File: rtl/pfail_seq_chk.sv
// Checker for the sequencer; observes ports only.
// Assumes: nested comparator flags, as stated in the brief.
module pfail_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       write_protect_o,
    input logic       inputs_ignored_o,
    input logic       outputs_hiz_o,
    input logic       backup_on_o,
    input logic       seal_released_o,
    input logic [1:0] state_o
);
    p_seal_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seal_released_o |=> seal_released_o);

    p_no_reseal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'd0) |=> (state_o != 2'd0));

    p_sealed_no_backup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0) |-> !backup_on_o);

    p_open_only_normal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(write_protect_o && inputs_ignored_o && outputs_hiz_o) |-> (state_o == 2'd1));

    p_backup_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3) |=> (state_o == 2'd3 || state_o == 2'd2));

    p_normal_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3) |=> (state_o != 2'd1));
endmodule

bind pfail_seq pfail_seq_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .write_protect_o (write_protect_o),
    .inputs_ignored_o(inputs_ignored_o),
    .outputs_hiz_o   (outputs_hiz_o),
    .backup_on_o     (backup_on_o),
    .seal_released_o (seal_released_o),
    .state_o         (state_o)
);

// File: tb/pfail_seq_test.sv
// Bench: directed latency checks plus every four-step supply-level sequence.
module pfail_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       full_f = 1'b0, prot_f = 1'b0, swo_f = 1'b0;
    logic       wp, ign, hiz, bkp, seal;
    logic [1:0] st;
    int         checks = 0, errors = 0;

    always #4 clk = ~clk;

    pfail_seq uut (
        .clk(clk), .rst_n(rst_n),
        .above_full_i(full_f), .above_prot_i(prot_f), .above_swo_i(swo_f),
        .write_protect_o(wp), .inputs_ignored_o(ign), .outputs_hiz_o(hiz),
        .backup_on_o(bkp), .seal_released_o(seal), .state_o(st)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_level(input int lvl);
        swo_f  = (lvl >= 1);
        prot_f = (lvl >= 2);
        full_f = (lvl >= 3);
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        set_level(0);
        edges(3);
        rst_n = 1'b1;
        edges(1);
    endtask

    // Requirement-level model: one state step for a level.
    function automatic int step(input int m, input int lvl);
        bit f = (lvl >= 3), p = (lvl >= 2), s = (lvl >= 1);
        case (m)
            0: return p ? (f ? 1 : 2) : 0;
            1: return !p ? (s ? 2 : 3) : 1;
            2: return (f && p) ? 1 : (!s ? 3 : 2);
            default: return s ? 2 : 3;
        endcase
    endfunction

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        set_level(0);
        edges(3);
        check("R1 state in reset", st, 0);
        check("R1 gates in reset", {wp, ign, hiz}, 7);
        rst_n = 1'b1;
        edges(4);
        check("R1 state after reset", st, 0);
        check("R1 backup after reset", bkp, 0);
        check("R1 seal after reset", seal, 0);

        // R9 / R2: power-up latency, straight to normal
        set_level(3);
        edges(2);
        check("R9 state still sealed after two edges", st, 0);
        edges(1);
        check("R9 normal on third edge (R2)", st, 1);
        check("R2 seal released", seal, 1);
        check("R4 gates open in normal", {wp, ign, hiz}, 0);

        // R5: hysteresis
        set_level(2);
        edges(6);
        check("R5 normal kept with full low", st, 1);
        check("R5 gates open with full low", wp, 0);

        // R6: protect latency from normal
        set_level(1);
        edges(1);
        check("R6 gates open one edge after drop", wp, 0);
        edges(1);
        check("R6 write protect on second edge", wp, 1);
        check("R6 inputs ignored on second edge", ign, 1);
        check("R6 outputs hiz on second edge", hiz, 1);
        check("R6 state still normal then", st, 1);
        edges(1);
        check("R6 protected on third edge", st, 2);

        // R8: protect level alone does not resume
        set_level(2);
        edges(6);
        check("R8 stays protected without full", st, 2);
        check("R8 gates closed without full", wp, 1);

        // R3: sealed below switchover keeps backup off
        do_reset();
        set_level(0);
        edges(8);
        check("R3 sealed state at zero level", st, 0);
        check("R3 backup off while sealed", bkp, 0);
        set_level(1);
        edges(6);
        check("R3 sealed at switchover level", st, 0);

        // Sweep: every four-step level sequence from reset
        for (int code = 0; code < 256; code++) begin
            int m, ms;
            do_reset();
            m = 0;
            ms = 0;
            for (int k = 0; k < 4; k++) begin
                int lvl = (code >> (2 * k)) & 3;
                set_level(lvl);
                for (int it = 0; it < 3; it++) begin
                    if (m == 0 && lvl >= 2) ms = 1;
                    m = step(m, lvl);
                end
                edges(7);
                case (m)
                    0: check("R3 sweep state", st, m);
                    1: check("R4 sweep state", st, m);
                    2: check("R8 sweep state", st, m);
                    default: check("R7 sweep state", st, m);
                endcase
                check("R4 sweep gates", {wp, ign, hiz}, (m == 1) ? 0 : 7);
                check("R7 sweep backup", bkp, (m == 3) ? 1 : 0);
                check("R2 sweep seal", seal, ms);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule